// File: doc/BRIEF.md
# Comparator Crossing Timestamp Recorder

This block turns a one-bit comparator into a time-domain measurement of a baseband feedback waveform. The comparator output reaches the block as two already-registered bits: one sampled straight from the comparator and one sampled after a fixed analog delay of a few nanoseconds. When the waveform crosses the threshold, the two bits briefly disagree. In every sample cycle where they disagree, the block stores a record in a small FIFO. Each record holds the reading of a free-running cycle counter, the direction of the crossing and the threshold code in force at that moment.

The block also holds the threshold code that drives a slow threshold DAC. After every threshold write it waits a programmable number of cycles before it accepts crossings again, so that no record is tied to a threshold that is still moving. A start pulse clears the counter, the FIFO and the overflow flag and arms the block. A stop pulse disarms it. Software then reads the records through a show-ahead read port. The detect and record path is fully registered, so it can run at a fast sample clock.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset, rd_valid, overflow and armed are 0, thr_code is 0 and thr_settled is 1.
- R2: Each sampled cycle in which cmp_direct differs from cmp_delayed produces exactly one record, so a two-cycle disagreement gives two records. Cycles with equal bits, whether both 0 or both 1, produce none.
- R3: The record layout is: rd_data[31:0] holds the timestamp, bit 32 the polarity and bits [44:33] the threshold code. The timestamp equals the number of rising clock edges from the edge that sampled arm_start (counted as 0) to the edge that sampled the disagreeing pair.
- R4: The polarity bit is 1 (rising crossing) when cmp_direct was 1 in the disagreeing pair, and 0 (falling crossing) when it was 0.
- R5: A thr_wr pulse loads thr_code_in into thr_code at that edge, and the records that follow carry the new code.
- R6: After a threshold write sampled at edge W with settle value N, a disagreement sampled at edge E gives a record only if E >= W+N. thr_settled is 0 from the edge after W until N edges have passed.
- R7: While disarmed (after reset or after arm_stop), disagreements produce no record. arm_start empties the FIFO, clears overflow and restarts the counter at 0.
- R8: When the FIFO already holds DEPTH (default 8) records, new records are dropped and overflow is set. It stays set until the next arm_start.
- R9: Records are read in capture order. rd_data shows the oldest record whenever rd_valid is 1, and rd_en pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_start | input | 1 | Pulse: clear counter, FIFO and overflow, then arm |
| arm_stop | input | 1 | Pulse: disarm |
| thr_wr | input | 1 | Pulse: load a new threshold code |
| thr_code_in | input | 12 | Threshold code to load |
| settle_cycles | input | 16 | Number of quiet cycles after each threshold write |
| cmp_direct | input | 1 | Registered comparator bit, direct path |
| cmp_delayed | input | 1 | Registered comparator bit, delayed path |
| rd_en | input | 1 | Pop the oldest record |
| rd_data | output | 45 | Oldest record {threshold, polarity, timestamp} |
| rd_valid | output | 1 | FIFO holds at least one record |
| overflow | output | 1 | Sticky: a record was dropped because the FIFO was full |
| armed | output | 1 | Block is recording |
| thr_code | output | 12 | Threshold code sent to the DAC |
| thr_settled | output | 1 | Settle period after the last threshold write has ended |

## Verification
The assertions check on every cycle that:
- a detect strobe traces back to a disagreeing input pair two edges earlier, with the matching polarity;
- no detection happens while the block is disarmed or the threshold is still settling;
- threshold loads take effect at the next edge and start a settle period;
- a full FIFO stays full unless it is read;
- overflow stays set until the next start.

Only the bench scenarios can show the exact timestamp arithmetic relative to the start edge, the record layout and FIFO order, the exact boundary of the settle window, and which records are kept when more events arrive than the FIFO can hold.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
  localparam int TS_W    = 32;
  localparam int THR_W   = 12;
  localparam int ENTRY_W = TS_W + 1 + THR_W;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             rising;
    logic [TS_W-1:0]  ts;
  } stamp_t;

  // A crossing is present when the direct and delayed samples disagree.
  function automatic logic is_crossing(input logic dir_bit, input logic dly_bit);
    return dir_bit ^ dly_bit;
  endfunction

  function automatic stamp_t make_stamp(input logic [TS_W-1:0] ts,
                                        input logic rising,
                                        input logic [THR_W-1:0] thr);
    stamp_t s;
    s.thr    = thr;
    s.rising = rising;
    s.ts     = ts;
    return s;
  endfunction

  function automatic logic [15:0] settle_next(input logic [15:0] cur);
    return (cur == 16'd0) ? 16'd0 : cur - 16'd1;
  endfunction
endpackage

// File: rtl/edge_sampler.sv
module edge_sampler
  import edge_stamp_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            enable,
  input  logic            cmp_direct,
  input  logic            cmp_delayed,
  input  logic [TS_W-1:0] ts_in,
  output logic            det_fire,
  output logic            det_pol,
  output logic [TS_W-1:0] det_ts
);
  logic [SYNC_STAGES-1:0] dir_sh, dly_sh;
  logic                   dir_s, dly_s;

  // Both bits get the same number of extra stages, so they stay aligned.
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_sh <= '0;
          dly_sh <= '0;
        end else begin
          dir_sh <= cmp_direct;
          dly_sh <= cmp_delayed;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_sh <= '0;
          dly_sh <= '0;
        end else begin
          dir_sh <= {dir_sh[SYNC_STAGES-2:0], cmp_direct};
          dly_sh <= {dly_sh[SYNC_STAGES-2:0], cmp_delayed};
        end
      end
    end
  endgenerate

  assign dir_s = dir_sh[SYNC_STAGES-1];
  assign dly_s = dly_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_fire <= 1'b0;
      det_pol  <= 1'b0;
      det_ts   <= '0;
    end else begin
      det_fire <= clear ? 1'b0 : (enable & is_crossing(dir_s, dly_s));
      det_pol  <= dir_s;
      det_ts   <= ts_in;
    end
  end
endmodule

// File: rtl/thr_holder.sv
module thr_holder
  import edge_stamp_pkg::*;
#(
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                thr_wr,
  input  logic [THR_W-1:0]    thr_code_in,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [THR_W-1:0]    thr_code,
  output logic                thr_settled
);
  logic [SETTLE_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_code <= '0;
      remain   <= '0;
    end else if (thr_wr) begin
      thr_code <= thr_code_in;
      remain   <= settle_cycles;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign thr_settled = (remain == '0);
endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 45
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         full,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         empty, push, pop;

  assign empty    = (wptr == rptr);
  assign full     = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);
  assign push     = wr_en && !full && !clear;
  assign pop      = rd_en && !empty && !clear;
  assign rd_valid = !empty;
  assign rd_data  = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      wptr     <= '0;
      rptr     <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      if (wr_en && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
  import edge_stamp_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int SETTLE_W    = 16,
  parameter int SYNC_STAGES = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_start,
  input  logic                arm_stop,
  input  logic                thr_wr,
  input  logic [THR_W-1:0]    thr_code_in,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cmp_direct,
  input  logic                cmp_delayed,
  input  logic                rd_en,
  output logic [ENTRY_W-1:0]  rd_data,
  output logic                rd_valid,
  output logic                overflow,
  output logic                armed,
  output logic [THR_W-1:0]    thr_code,
  output logic                thr_settled
);
  logic [TS_W-1:0] stamp_cnt;
  logic            det_fire, det_pol;
  logic [TS_W-1:0] det_ts;
  logic            fifo_full;
  logic            det_enable;
  stamp_t          entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      stamp_cnt <= '0;
    end else if (arm_start) begin
      armed     <= 1'b1;
      stamp_cnt <= '0;
    end else begin
      if (arm_stop) armed <= 1'b0;
      if (armed)    stamp_cnt <= stamp_cnt + 1'b1;
    end
  end

  assign det_enable = armed && thr_settled;

  thr_holder #(.SETTLE_W(SETTLE_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_code_in(thr_code_in),
    .settle_cycles(settle_cycles), .thr_code(thr_code), .thr_settled(thr_settled)
  );

  edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .clear(arm_start), .enable(det_enable),
    .cmp_direct(cmp_direct), .cmp_delayed(cmp_delayed), .ts_in(stamp_cnt),
    .det_fire(det_fire), .det_pol(det_pol), .det_ts(det_ts)
  );

  assign entry = make_stamp(det_ts, det_pol, thr_code);

  stamp_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(arm_start), .wr_en(det_fire),
    .wr_data(entry), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .full(fifo_full), .overflow(overflow)
  );
endmodule

// File: rtl/edge_stamp_checker.sv
module edge_stamp_checker
  import edge_stamp_pkg::*;
#(
  parameter int SETTLE_W    = 16,
  parameter int SYNC_STAGES = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                arm_start,
  input logic                thr_wr,
  input logic [THR_W-1:0]    thr_code_in,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic                cmp_direct,
  input logic                cmp_delayed,
  input logic                rd_en,
  input logic                armed,
  input logic                overflow,
  input logic [THR_W-1:0]    thr_code,
  input logic                thr_settled,
  input logic                det_fire,
  input logic                det_pol,
  input logic                fifo_full
);
  a_r2_det_from_disagree: assert property (@(posedge clk) disable iff (!rst_n)
    det_fire |-> ($past(cmp_direct, SYNC_STAGES+1) != $past(cmp_delayed, SYNC_STAGES+1)));

  a_r4_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    det_fire |-> (det_pol == $past(cmp_direct, SYNC_STAGES+1)));

  a_r5_thr_load: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_code == $past(thr_code_in)));

  a_r6_settle_begins: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && settle_cycles != '0) |=> !thr_settled);

  a_r6_no_det_settling: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_settled |=> !det_fire);

  a_r7_no_det_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !det_fire);

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm_start |=> (armed && !overflow));

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_en && !arm_start) |=> fifo_full);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !arm_start) |=> overflow);
endmodule

bind edge_stamp_capture edge_stamp_checker #(.SETTLE_W(SETTLE_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_start(arm_start), .thr_wr(thr_wr),
  .thr_code_in(thr_code_in), .settle_cycles(settle_cycles),
  .cmp_direct(cmp_direct), .cmp_delayed(cmp_delayed), .rd_en(rd_en),
  .armed(armed), .overflow(overflow), .thr_code(thr_code),
  .thr_settled(thr_settled), .det_fire(det_fire), .det_pol(det_pol),
  .fifo_full(fifo_full)
);

// File: tb/edge_stamp_capture_test.sv
`timescale 1ns/1ps
module edge_stamp_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_start = 1'b0, arm_stop = 1'b0, thr_wr = 1'b0;
  logic [11:0] thr_code_in = '0;
  logic [15:0] settle_cycles = '0;
  logic        cmp_direct = 1'b0, cmp_delayed = 1'b0;
  logic        rd_en = 1'b0;
  logic [44:0] rd_data;
  logic        rd_valid, overflow, armed, thr_settled;
  logic [11:0] thr_code;

  edge_stamp_capture uut (
    .clk(clk), .rst_n(rst_n), .arm_start(arm_start), .arm_stop(arm_stop),
    .thr_wr(thr_wr), .thr_code_in(thr_code_in), .settle_cycles(settle_cycles),
    .cmp_direct(cmp_direct), .cmp_delayed(cmp_delayed), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow),
    .armed(armed), .thr_code(thr_code), .thr_settled(thr_settled)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int bcyc = 0;
  bit done = 0;
  logic [44:0] expq[$];

  // bench model state
  bit b_armed = 0;
  int b_start = 0;
  int b_wedge = -1000;
  int b_settle = 0;
  logic [11:0] b_thr = '0;
  bit mon_on = 1;

  always @(posedge clk) bcyc <= bcyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) if (bcyc > 20000) begin
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", bcyc, 20000);
    finish_run();
  end

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rd_en) rd_en = 1'b0;
    else if (mon_on && rd_valid && rst_n) begin
      if (expq.size() == 0) chk(0, "R2/R9 unexpected record", {19'd0, rd_data}, 64'd0);
      else begin
        logic [44:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R3/R4/R5/R9 record", {19'd0, rd_data}, {19'd0, e});
      end
      rd_en = 1'b1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk);
    arm_start = 1'b1;
    b_start = bcyc + 1;
    b_armed = 1;
    expq.delete();
    @(negedge clk);
    arm_start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk);
    arm_stop = 1'b1;
    b_armed = 0;
    @(negedge clk);
    arm_stop = 1'b0;
  endtask

  task automatic write_thr(input logic [11:0] v, input int s);
    @(negedge clk);
    thr_wr = 1'b1; thr_code_in = v; settle_cycles = s[15:0];
    b_wedge = bcyc + 1; b_settle = s; b_thr = v;
    @(negedge clk);
    thr_wr = 1'b0;
    chk(thr_code == v, "R5 thr_code load", {52'd0, thr_code}, {52'd0, v});
  endtask

  // drive one input pair for n cycles; queue the records the rules predict
  task automatic drive(input logic d, input logic l, input int n, input int cap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_direct = d; cmp_delayed = l;
      if (b_armed && (d != l) && (bcyc + 1 >= b_wedge + b_settle) && expq.size() < cap) begin
        logic [31:0] ts;
        ts = bcyc + 1 - b_start;
        expq.push_back({b_thr, d, ts});
      end
    end
    @(negedge clk);
    cmp_direct = 1'b0; cmp_delayed = 1'b0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 200 && (expq.size() != 0 || rd_valid); k++) @(negedge clk);
    chk(expq.size() == 0, "R9 all expected records seen", expq.size(), 0);
  endtask

  initial begin
    idle(3);
    // R1 reset state
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    chk(armed == 0, "R1 armed", armed, 0);
    chk(thr_code == 0, "R1 thr_code", thr_code, 0);
    chk(thr_settled == 1, "R1 thr_settled", thr_settled, 1);
    rst_n = 1'b1;
    idle(2);

    // R7 disarmed: crossings ignored
    drive(1, 0, 1, 8);
    drive(0, 1, 2, 8);
    idle(6);
    chk(rd_valid == 0, "R7 disarmed no record", rd_valid, 0);

    // R6 settle window, then R2/R3/R4 main patterns
    write_thr(12'h155, 20);
    chk(thr_settled == 0, "R6 settling flag", thr_settled, 0);
    do_start();
    chk(armed == 1, "R7 armed after start", armed, 1);
    drive(1, 0, 1, 8);
    idle(6);
    chk(rd_valid == 0, "R6 no record while settling", rd_valid, 0);
    idle(20);
    chk(thr_settled == 1, "R6 settled", thr_settled, 1);
    drive(1, 0, 1, 8);
    idle(3);
    drive(0, 1, 1, 8);
    idle(3);
    drive(1, 1, 3, 8);
    idle(3);
    drive(1, 0, 2, 8);
    idle(3);
    wait_drain();

    // R5 threshold change while armed, settle boundary exactly at edge W+N
    write_thr(12'h0AA, 8);
    drive(0, 1, 1, 8);
    idle(2);
    for (int k = 0; k < 6; k++) drive(1, 0, 1, 8);
    idle(4);
    wait_drain();

    // R7 stop
    do_stop();
    chk(armed == 0, "R7 armed after stop", armed, 0);
    drive(1, 0, 2, 8);
    idle(6);
    chk(rd_valid == 0, "R7 stopped no record", rd_valid, 0);

    // R8 overflow
    do_start();
    mon_on = 0;
    for (int k = 0; k < 11; k++) begin
      drive(k % 2 == 0, k % 2 != 0, 1, 8);
      idle(1);
    end
    idle(4);
    chk(overflow == 1, "R8 overflow set", overflow, 1);
    idle(3);
    chk(overflow == 1, "R8 overflow sticky", overflow, 1);
    mon_on = 1;
    wait_drain();
    chk(overflow == 1, "R8 overflow survives drain", overflow, 1);

    // R7 start clears FIFO and overflow
    mon_on = 0;
    for (int k = 0; k < 10; k++) drive(1, 0, 1, 8);
    idle(4);
    do_start();
    chk(rd_valid == 0, "R7 start empties fifo", rd_valid, 0);
    chk(overflow == 0, "R7 start clears overflow", overflow, 0);
    mon_on = 1;
    idle(2);
    drive(0, 1, 1, 8);
    idle(4);
    wait_drain();

    finish_run();
  end
endmodule